// File: doc/BRIEF.md
# Address Security Attribution Unit

The unit gives every 32-bit address a final security attribute. The three attributes are secure, non-secure callable and non-secure. It combines two sources. The first is a fixed map wired into the hardware. In that map each internal memory and peripheral window appears twice: once as a non-secure view and once as a secure alias that is reported as non-secure callable. The second source is a table of eight regions that software programs. Each region has a base, a limit, a callable flag and an enable. A single global enable switches the whole table on or off.

Software configures the table through a one-cycle write port. A lookup is issued with a valid strobe, an address and a flag that marks it as an instruction fetch. The registered answer appears one cycle later. For a fetch, the unit also reports whether the transaction must be issued as non-secure. The final attribute is always the more secure of the two maps. An address that no enabled region covers falls back to secure.

Top module: `sec_attr_unit`

## Requirements
- R1: Eight regions are programmed through `cfg_we`, `cfg_kind` and `cfg_idx`. `cfg_kind`=0 writes the global enable from `cfg_wdata[0]`. `cfg_kind`=1 writes the region base from `cfg_wdata[31:5]`. `cfg_kind`=2 writes three things: the region limit from `cfg_wdata[31:5]`, the callable flag from `cfg_wdata[1]` and the region enable from `cfg_wdata[0]`. `cfg_kind`=3 changes nothing.
- R2: While the global enable is 0, every lookup returns secure. The attribute codes are: non-secure=0, non-secure callable=1, secure=2.
- R3: With the table enabled, an address below 0xE000_0000 that no enabled region covers returns secure.
- R4: The final attribute is the higher of the fixed-map code and the table code, using the codes given in R2.
- R5: The fixed map gives non-secure for 0x0000_0000–0x0BFF_FFFF, 0x1000_0000–0x2FFF_FFFF, 0x4000_0000–0x4FFF_FFFF and 0x6000_0000–0xDFFF_FFFF.
- R6: The fixed map gives non-secure callable for the three secure aliases: 0x0C00_0000–0x0FFF_FFFF, 0x3000_0000–0x3FFF_FFFF and 0x5000_0000–0x5FFF_FFFF.
- R7: An address at 0xE000_0000 or above returns secure, whatever the table holds.
- R8: `rsp_fetch_ns` is 1 only for a fetch lookup whose final attribute is non-secure. It is 0 for any other response.
- R9: A region covers an address when base <= address <= (limit OR 0x1F). Region bounds have a granularity of 32 bytes.
- R10: When several enabled regions cover an address, the region with the lowest number sets the table result.
- R11: A response appears exactly one cycle after its request. A configuration write takes effect for lookups from the next cycle on, so a lookup in the same cycle as the write sees the old setting. After reset, the global enable and all regions are off, `rsp_valid` is 0, `rsp_attr` is 2 and `rsp_fetch_ns` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Selects what is written: control, base or limit |
| cfg_idx | input | 3 | Number of the region being written |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Address to classify |
| req_fetch | input | 1 | The lookup is an instruction fetch |
| rsp_valid | output | 1 | A response is present this cycle |
| rsp_attr | output | 2 | Final attribute (0 non-secure, 1 callable, 2 secure) |
| rsp_fetch_ns | output | 1 | The fetch goes out as a non-secure transaction |

## Verification
The bench builds the unit with its default parameters: eight regions, 32-bit addresses and a 32-byte granule. These values make every boundary of the fixed map reachable. They also allow overlapping regions with mixed callable flags, so the lowest-number rule can be seen at the ports. A behavioural model predicts each response and is compared every cycle. The directed sequences cover alias ranges, region edges with inclusive limits, writes in the same cycle as a lookup, and the band above 0xE000_0000. A random phase follows, mixing writes to all regions with lookups.

// File: rtl/sau_pkg.sv
// Shared attribute encoding and configuration kinds for the attribution unit.
// Assumes a higher code means a more secure attribute.
package sau_pkg;
    typedef enum logic [1:0] {
        ATTR_NS  = 2'b00,
        ATTR_NSC = 2'b01,
        ATTR_SEC = 2'b10
    } attr_e;

    localparam logic [1:0] CFG_CTRL  = 2'd0;
    localparam logic [1:0] CFG_BASE  = 2'd1;
    localparam logic [1:0] CFG_LIMIT = 2'd2;

    // Returns the more secure of two attributes.
    function automatic attr_e attr_max(input attr_e a, input attr_e b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sau_fixed_map.sv
// Hard-wired attribute map with aliased views.
// Input: the top six address bits. The external band is not aliased, and the
// band at 0xE000_0000 and above is secure. Assumes 32-bit addresses.
module sau_fixed_map
    import sau_pkg::*;
(
    input  logic [5:0] addr_top,
    output attr_e      fixed_attr
);
    logic [3:0] nib;
    assign nib = addr_top[5:2];

    // Decode the 256 MB window, then the 64 MB quarter inside the code window.
    always_comb begin
        unique case (nib)
            4'h0:    fixed_attr = (addr_top[1:0] == 2'b11) ? ATTR_NSC : ATTR_NS;
            4'h1, 4'h2, 4'h4: fixed_attr = ATTR_NS;
            4'h3, 4'h5:       fixed_attr = ATTR_NSC;
            4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: fixed_attr = ATTR_NS;
            default: fixed_attr = ATTR_SEC;
        endcase
    end
endmodule

// File: rtl/sau_region_table.sv
// Programmable region table: per-region base, limit, callable flag and enable,
// plus the global enable. Classifies an address without a register stage.
// Assumes bounds are kept at GRAN_LOG2 granularity and the limit is inclusive.
module sau_region_table
    import sau_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    parameter int GRAN_LOG2   = 5,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    localparam int HI_W       = ADDR_W - GRAN_LOG2
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_kind,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [HI_W-1:0]        cfg_hi,
    input  logic                   cfg_nsc,
    input  logic                   cfg_en,
    input  logic [HI_W-1:0]        lk_hi,
    output logic                   glob_en,
    output logic [NUM_REGIONS-1:0] hit_vec,
    output logic [NUM_REGIONS-1:0] win_vec,
    output attr_e                  tbl_attr
);
    logic [NUM_REGIONS-1:0] nsc_vec;

    // Global enable register, written through the control kind.
    always_ff @(posedge clk) begin
        if (!rst_n)
            glob_en <= 1'b0;
        else if (cfg_we && cfg_kind == CFG_CTRL)
            glob_en <= cfg_en;
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
        logic [HI_W-1:0] base_q;
        logic [HI_W-1:0] lim_q;
        logic            en_q;
        logic            nsc_q;

        // Per-region storage, updated when this region is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                lim_q  <= '0;
                en_q   <= 1'b0;
                nsc_q  <= 1'b0;
            end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
                if (cfg_kind == CFG_BASE)
                    base_q <= cfg_hi;
                else if (cfg_kind == CFG_LIMIT) begin
                    lim_q <= cfg_hi;
                    nsc_q <= cfg_nsc;
                    en_q  <= cfg_en;
                end
            end
        end

        // Inclusive range compare on granule-aligned upper bits.
        assign hit_vec[g] = en_q && (lk_hi >= base_q) && (lk_hi <= lim_q);
        assign nsc_vec[g] = nsc_q;
    end

    // The lowest-numbered hit wins: isolate the least significant set bit.
    assign win_vec = hit_vec & (~hit_vec + NUM_REGIONS'(1));

    // Table result: secure when the table is off or nothing covers the address.
    always_comb begin
        if (!glob_en || hit_vec == '0)
            tbl_attr = ATTR_SEC;
        else if ((win_vec & nsc_vec) != '0)
            tbl_attr = ATTR_NSC;
        else
            tbl_attr = ATTR_NS;
    end

    // R1
    region_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_kind == CFG_LIMIT && !cfg_en) |=> !hit_vec[$past(cfg_idx)]);

    // R10
    win_in_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec != '0) |-> ($onehot(win_vec) && ((win_vec & ~hit_vec) == '0)));
endmodule

// File: rtl/sec_attr_unit.sv
// Top of the attribution unit. Merges the fixed map with the region table,
// forces secure above the mapped space, and registers the response.
// Assumes one lookup per cycle; the response follows one cycle later.
module sec_attr_unit
    import sau_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    parameter int GRAN_LOG2   = 5,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    localparam int HI_W       = ADDR_W - GRAN_LOG2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_fetch,
    output logic              rsp_valid,
    output logic [1:0]        rsp_attr,
    output logic              rsp_fetch_ns
);
    attr_e                  fixed_attr;
    attr_e                  tbl_attr;
    attr_e                  merged;
    attr_e                  attr_q;
    logic                   glob_en;
    logic                   high_band;
    logic [NUM_REGIONS-1:0] hit_vec;
    logic [NUM_REGIONS-1:0] win_vec;
    logic                   unused_bits;

    assign unused_bits = ^{cfg_wdata[GRAN_LOG2-1:2], req_addr[GRAN_LOG2-1:0]};

    sau_fixed_map i_fixed (
        .addr_top   (req_addr[ADDR_W-1 -: 6]),
        .fixed_attr (fixed_attr)
    );

    sau_region_table #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W),
        .GRAN_LOG2   (GRAN_LOG2)
    ) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_kind (cfg_kind),
        .cfg_idx  (cfg_idx),
        .cfg_hi   (cfg_wdata[ADDR_W-1:GRAN_LOG2]),
        .cfg_nsc  (cfg_wdata[1]),
        .cfg_en   (cfg_wdata[0]),
        .lk_hi    (req_addr[ADDR_W-1:GRAN_LOG2]),
        .glob_en  (glob_en),
        .hit_vec  (hit_vec),
        .win_vec  (win_vec),
        .tbl_attr (tbl_attr)
    );

    // Band at 0xE000_0000 and above bypasses both maps.
    assign high_band = (req_addr[ADDR_W-1 -: 3] == 3'b111);

    // Final attribute: the more secure source, or secure in the high band.
    always_comb begin
        if (high_band)
            merged = ATTR_SEC;
        else
            merged = attr_max(fixed_attr, tbl_attr);
    end

    // Response register; the attribute holds between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            attr_q       <= ATTR_SEC;
            rsp_fetch_ns <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_fetch_ns <= req_valid && req_fetch && (merged == ATTR_NS);
            if (req_valid)
                attr_q <= merged;
        end
    end

    assign rsp_attr = attr_q;

    // R2
    dis_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !glob_en) |=> (rsp_attr == ATTR_SEC));

    // R4
    fixed_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_attr >= $past(fixed_attr)));

    // R7
    high_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1 -: 3] == 3'b111) |=> (rsp_attr == ATTR_SEC));

    // R8
    fetch_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fetch_ns |-> (rsp_valid && rsp_attr == ATTR_NS));

    // R11
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fetch_ns));
endmodule

// File: tb/test_sec_attr_unit.sv
`timescale 1ns/1ps
module test_sec_attr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = 2'd0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = 32'd0;
    logic        req_fetch = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_attr;
    logic        rsp_fetch_ns;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    logic [31:0] m_base [8];
    logic [31:0] m_lim  [8];
    bit          m_nsc  [8];
    bit          m_en   [8];
    bit          m_glob;
    bit          e_valid;
    logic [1:0]  e_attr;
    bit          e_fns;

    always #2 clk = ~clk;

    sec_attr_unit i_sec_attr_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_fetch(req_fetch), .rsp_valid(rsp_valid),
        .rsp_attr(rsp_attr), .rsp_fetch_ns(rsp_fetch_ns)
    );

    function automatic logic [1:0] ref_fixed(input logic [31:0] a);
        if (a < 32'h0C00_0000) return 2'd0;
        if (a < 32'h1000_0000) return 2'd1;
        if (a < 32'h3000_0000) return 2'd0;
        if (a < 32'h4000_0000) return 2'd1;
        if (a < 32'h5000_0000) return 2'd0;
        if (a < 32'h6000_0000) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [1:0] ref_table(input logic [31:0] a);
        if (!m_glob) return 2'd2;
        for (int i = 0; i < 8; i++)
            if (m_en[i] && a >= m_base[i] && a <= m_lim[i])
                return m_nsc[i] ? 2'd1 : 2'd0;
        return 2'd2;
    endfunction

    function automatic logic [1:0] ref_attr(input logic [31:0] a);
        logic [1:0] f, t;
        if (a >= 32'hE000_0000) return 2'd2;
        f = ref_fixed(a);
        t = ref_table(a);
        return (f > t) ? f : t;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_base[i] = 0; m_lim[i] = 32'h1F; m_nsc[i] = 0; m_en[i] = 0;
        end
        m_glob = 0; e_valid = 0; e_attr = 2'd2; e_fns = 0;
    endtask

    // One clock: predict from inputs set at the last falling edge, compare after.
    task automatic tick(input string tag);
        @(posedge clk);
        e_valid = req_valid;
        if (req_valid) begin
            e_attr = ref_attr(req_addr);
            e_fns  = req_fetch && (e_attr == 2'd0);
        end else begin
            e_fns = 0;
        end
        if (cfg_we) begin
            case (cfg_kind)
                2'd0: m_glob = cfg_wdata[0];
                2'd1: m_base[cfg_idx] = cfg_wdata & 32'hFFFF_FFE0;
                2'd2: begin
                    m_lim[cfg_idx] = cfg_wdata | 32'h1F;
                    m_nsc[cfg_idx] = cfg_wdata[1];
                    m_en[cfg_idx]  = cfg_wdata[0];
                end
                default: ;
            endcase
        end
        @(negedge clk);
        checks++;
        if (rsp_valid !== e_valid || rsp_attr !== e_attr || rsp_fetch_ns !== e_fns) begin
            errors++;
            $display("FAIL %s addr=%h: got valid=%0d attr=%0d fns=%0d expected valid=%0d attr=%0d fns=%0d",
                     tag, req_addr, rsp_valid, rsp_attr, rsp_fetch_ns, e_valid, e_attr, e_fns);
        end
        cfg_we = 0; req_valid = 0; req_fetch = 0;
    endtask

    task automatic wr(input logic [1:0] k, input logic [2:0] idx, input logic [31:0] d);
        cfg_we = 1; cfg_kind = k; cfg_idx = idx; cfg_wdata = d;
        tick("R1");
    endtask

    task automatic lk(input logic [31:0] a, input bit f, input string tag);
        req_valid = 1; req_addr = a; req_fetch = f;
        tick(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no completion, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_attr !== 2'd2 || rsp_fetch_ns !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset: got %0d/%0d/%0d expected 0/2/0", rsp_valid, rsp_attr, rsp_fetch_ns);
        end
        rst_n = 1;
        tick("R11");

        // R2: table disabled, everything secure
        lk(32'h0000_0000, 1, "R2");
        lk(32'h2000_1000, 0, "R2");
        lk(32'h4000_0000, 1, "R2");
        lk(32'h9000_0000, 0, "R2");
        // enabled region present but global off
        wr(2'd1, 3'd0, 32'h0000_0000);
        wr(2'd2, 3'd0, 32'hDFFF_FFE0 | 32'h1);
        lk(32'h2000_0000, 1, "R2");

        // R5/R6: table covers all below 0xE000_0000 as non-secure
        wr(2'd0, 3'd0, 32'h1);
        lk(32'h0000_0000, 1, "R5");
        lk(32'h07FF_FFFF, 0, "R5");
        lk(32'h0800_0000, 1, "R5");
        lk(32'h0BFF_FFFF, 0, "R5");
        lk(32'h0C00_0000, 1, "R6");
        lk(32'h0FFF_FFFF, 0, "R6");
        lk(32'h1000_0000, 1, "R5");
        lk(32'h2FFF_FFFC, 1, "R5");
        lk(32'h3000_0000, 1, "R6");
        lk(32'h3FFF_FFFF, 0, "R6");
        lk(32'h4000_0000, 1, "R5");
        lk(32'h5000_0000, 1, "R6");
        lk(32'h5FFF_FFFF, 0, "R6");
        lk(32'h6000_0000, 1, "R8");
        lk(32'hDFFF_FFFF, 1, "R5");

        // R7: high band secure even with a region there
        wr(2'd1, 3'd1, 32'hE000_0000);
        wr(2'd2, 3'd1, 32'hFFFF_FFE0 | 32'h1);
        lk(32'hE000_0000, 1, "R7");
        lk(32'hFFFF_FFFF, 0, "R7");

        // R9/R10/R3/R4: overlapping regions
        wr(2'd2, 3'd0, 32'hDFFF_FFE0);             // region 0 off
        wr(2'd1, 3'd2, 32'h2001_8000);
        wr(2'd2, 3'd2, 32'h2003_FFE0 | 32'h1);     // NS
        wr(2'd1, 3'd1, 32'h2002_0000);
        wr(2'd2, 3'd1, 32'h2002_0FE0 | 32'h3);     // NSC
        wr(2'd3, 3'd1, 32'h0);                     // ignored kind
        lk(32'h2002_0000, 1, "R10");
        lk(32'h2002_0FFF, 0, "R10");
        lk(32'h2002_1000, 1, "R9");
        lk(32'h2001_7FFF, 0, "R3");
        lk(32'h2001_8000, 1, "R9");
        lk(32'h2003_FFFF, 1, "R9");
        lk(32'h2004_0000, 0, "R3");
        lk(32'h0800_0000, 0, "R3");
        wr(2'd1, 3'd4, 32'h3000_0000);
        wr(2'd2, 3'd4, 32'h3000_FFE0 | 32'h1);     // NS region over callable alias
        lk(32'h3000_0100, 1, "R4");
        wr(2'd1, 3'd3, 32'h2002_0800);
        wr(2'd2, 3'd3, 32'h2002_0FE0 | 32'h1);     // higher number NS inside NSC
        lk(32'h2002_0800, 1, "R10");

        // R11: lookup in the write cycle sees the old setting
        cfg_we = 1; cfg_kind = 2'd0; cfg_idx = 0; cfg_wdata = 0;
        req_valid = 1; req_addr = 32'h2001_8000; req_fetch = 1;
        tick("R11");
        lk(32'h2001_8000, 1, "R11");
        tick("R11");
        wr(2'd0, 3'd0, 32'h1);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            if ($urandom_range(0, 3) == 0) begin
                cfg_we = 1; cfg_kind = 2'($urandom_range(0, 3));
                cfg_idx = 3'($urandom_range(0, 7));
                cfg_wdata = (cfg_kind == 2'd0) ? 32'($urandom_range(0, 7) != 0) : r;
            end
            if ($urandom_range(0, 3) != 0) begin
                req_valid = 1;
                req_addr  = ($urandom_range(0, 1) == 0) ? r : {4'h2, 8'h00, r[19:0]};
                req_fetch = r[0];
            end
            tick("R4");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule